// File: doc/BRIEF.md
# Mailbox-Commanded I2C Master

This block is an I2C bus master that a host controls through a handful of 16-bit registers. To start a transfer, the host first places up to two outgoing bytes in a transmit mailbox. It then writes one command word. That word gives the target address, the direction, a one- or two-byte count, an address-only probe flag and a flag to keep the bus afterwards. The engine then drives the bus on its own. It sends START or repeated START, then the address byte, then the data bytes with acknowledge handling, and ends with STOP unless the bus is kept.

When the transfer ends, the block sets a sticky event bit: transmit complete, receive complete or error. An interrupt line reports any event whose enable bit is set. Received bytes appear in a receive mailbox. A host transfer longer than two bytes is split into chunks of at most two bytes. Every chunk except the last carries the keep-bus flag, so the chunks are joined by repeated STARTs with no STOP between them.

SCL and SDA are open-drain. The block drives each line low through an output-enable and reads the line back through an input. Timing comes from a fixed divider: one bit takes four phases, and each phase lasts `CLK_DIV` clock cycles.

Top module: `i2cm_top`

## Requirements
- R1: The registers sit at byte offsets 0x0 (event status), 0x2 (event enable, only bits 15:13 are stored), 0x4 (transmit mailbox), 0x6 (command) and 0x8 (receive mailbox). Any other offset, and the command register, reads as zero. After reset every register reads zero, `irq` is low and both lines are released.
- R2: Status bit 13 is error, bit 14 is transmit complete and bit 15 is receive complete. Each bit stays set until the host writes 1 to that bit. Writing 0 to a bit leaves it unchanged.
- R3: `irq` is high exactly when some status bit is set and its enable bit at the same position is also set.
- R4: The engine accepts a command write only when bits 15:14 equal 2'b10 and the engine is idle. Any other command write causes no bus activity and changes no event.
- R5: In the command word, bits 7:1 hold the target address, bit 10 is 1 for a write, bit 11 is 1 for two bytes, bit 12 is 1 for an address-only probe and bit 13 is 1 to keep the bus. The address byte sent on the bus is {address, 1 for a read}.
- R6: A write sends transmit mailbox bits 7:0 first and bits 15:8 second (second byte only for two-byte commands). When every byte is acknowledged, the transmit-complete event is set.
- R7: A read places the first byte received in receive mailbox bits 7:0 and the second in bits 15:8. A one-byte read clears bits 15:8. The mailbox changes only when a read ends without error, and that read also sets the receive-complete event.
- R8: During a read, the master acknowledges every byte except the last byte of a command that releases the bus, which it does not acknowledge.
- R9: With the keep-bus bit set, no STOP is sent and SCL stays driven low afterwards, so the next command begins with a repeated START. With the bit clear, the transfer ends with a STOP.
- R10: A missing acknowledge after the address or a written byte sets only the error event. The engine then sends no further bytes, issues a STOP and returns to idle.
- R11: A probe sends only the address byte. On acknowledge it sets the receive-complete event (read probe) or transmit-complete event (write probe) and leaves the receive mailbox untouched. On a missing acknowledge it sets the error event.
- R12: While the engine drives the bus, each SCL high period lasts 2*`CLK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Enabled event pending |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest situations to reach are those where the target, not the host, decides the outcome. Examples are a missing acknowledge on a data byte partway through a two-byte write, and a repeated START that follows a command which kept the bus. A behavioural target on the open-drain lines handles these. It can be told which written byte to reject, it logs each byte and each master acknowledge bit, and it counts START and STOP conditions. The bench checks what happened on the wire against those logs and counters, not only against the event bits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // register byte offsets
    localparam logic [3:0] OFS_STAT = 4'h0;
    localparam logic [3:0] OFS_IEN  = 4'h2;
    localparam logic [3:0] OFS_TXMB = 4'h4;
    localparam logic [3:0] OFS_CMD  = 4'h6;
    localparam logic [3:0] OFS_RXMB = 4'h8;

    // event bits live in [EV_HI:EV_LO] = {rx, tx, err}
    localparam int EV_LO = 13;
    localparam int EV_HI = 15;
    localparam int EV_W  = EV_HI - EV_LO + 1;

    localparam logic [1:0] MODE_OK = 2'b10;

    typedef struct packed {
        logic [6:0] addr;
        logic       wr;
        logic       two;
        logic       probe;
        logic       hold;
    } cmd_t;

    typedef enum logic [1:0] {K_ADDR, K_WR, K_RD} kind_t;
    typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} est_t;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tk_t;

    tk_t q, n;

    always_comb begin
        n = q;
        if (q.cnt == LAST) n.cnt = '0;
        else               n.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tick_o = (q.cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R12
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  cmd_t                cmd_i,
    input  logic [15:0]         tx_i,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe_o,
    output logic                sda_oe_o,
    output logic                busy_o,
    output logic [EV_W-1:0]     ev_o,
    output logic                rxwe_o,
    output logic [15:0]         rx_o
);
    typedef struct packed {
        est_t        st;
        logic [1:0]  ph;
        logic [3:0]  bitn;
        logic [7:0]  sh;
        kind_t       kind;
        logic        bi;
        cmd_t        cmd;
        logic [15:0] tx;
        logic [15:0] rx;
        logic        scl;
        logic        sda;
        logic        held;
        logic        err;
        logic        nack;
        logic        done;
        logic        rxwe;
    } eng_t;

    eng_t q, n;
    logic adv, last, ok_end, go_stop;

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        n.rxwe  = 1'b0;
        ok_end  = 1'b0;
        go_stop = 1'b0;
        // phase 2 samples the line: wait there until SCL really reads high
        adv  = tick_i && !(q.ph == 2'd2 && !scl_i);
        last = (q.bi == q.cmd.two);
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    n.st   = S_START;
                    n.ph   = 2'd0;
                    n.cmd  = cmd_i;
                    n.tx   = tx_i;
                    n.rx   = '0;
                    n.err  = 1'b0;
                    n.kind = K_ADDR;
                    n.bitn = 4'd0;
                    n.bi   = 1'b0;
                    n.sh   = {cmd_i.addr, ~cmd_i.wr};
                end
            end
            S_START: begin
                if (adv) begin
                    n.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: n.sda = 1'b0;
                        2'd1: n.scl = 1'b0;
                        2'd2: n.sda = 1'b1;
                        default: begin
                            n.scl = 1'b1;
                            n.st  = S_BIT;
                        end
                    endcase
                end
            end
            S_BIT: begin
                if (adv) begin
                    n.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: begin
                            if (q.bitn < 4'd8)
                                n.sda = (q.kind != K_RD) && !q.sh[7];
                            else
                                n.sda = (q.kind == K_RD) && !(last && !q.cmd.hold);
                        end
                        2'd1: n.scl = 1'b0;
                        2'd2: begin
                            if (q.bitn < 4'd8) n.sh   = {q.sh[6:0], sda_i};
                            else               n.nack = sda_i;
                        end
                        default: begin
                            n.scl = 1'b1;
                            if (q.bitn != 4'd8) begin
                                n.bitn = q.bitn + 4'd1;
                            end else begin
                                n.bitn = 4'd0;
                                if (q.kind == K_RD) begin
                                    if (q.bi) n.rx[15:8] = q.sh;
                                    else      n.rx[7:0]  = q.sh;
                                    if (last) ok_end = 1'b1;
                                    else      n.bi   = 1'b1;
                                end else if (q.nack) begin
                                    n.err   = 1'b1;
                                    go_stop = 1'b1;
                                end else if (q.kind == K_ADDR) begin
                                    if (q.cmd.probe) begin
                                        ok_end = 1'b1;
                                    end else if (q.cmd.wr) begin
                                        n.kind = K_WR;
                                        n.sh   = q.tx[7:0];
                                    end else begin
                                        n.kind = K_RD;
                                    end
                                end else begin
                                    if (last) begin
                                        ok_end = 1'b1;
                                    end else begin
                                        n.bi = 1'b1;
                                        n.sh = q.tx[15:8];
                                    end
                                end
                                if (ok_end) begin
                                    if (q.cmd.hold) begin
                                        n.st   = S_IDLE;
                                        n.held = 1'b1;
                                        n.done = 1'b1;
                                        n.rxwe = (q.kind == K_RD);
                                    end else begin
                                        go_stop = 1'b1;
                                    end
                                end
                                if (go_stop) n.st = S_STOP;
                            end
                        end
                    endcase
                end
            end
            S_STOP: begin
                if (adv) begin
                    n.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: n.sda = 1'b1;
                        2'd1: n.scl = 1'b0;
                        2'd2: n.sda = 1'b0;
                        default: begin
                            n.st   = S_IDLE;
                            n.held = 1'b0;
                            n.done = 1'b1;
                            n.rxwe = !q.err && (q.kind == K_RD);
                        end
                    endcase
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign scl_oe_o = q.scl;
    assign sda_oe_o = q.sda;
    assign busy_o   = (q.st != S_IDLE);
    assign rxwe_o   = q.rxwe;
    assign rx_o     = q.rx;
    assign ev_o     = q.done ? {~q.err & ~q.cmd.wr, ~q.err & q.cmd.wr, q.err} : '0;

    // R4
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_o));
    // R10
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[0] |-> (!scl_oe_o && !sda_oe_o));
    // R9
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && q.held) |-> scl_oe_o);

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [3:0]      addr_i,
    input  logic [15:0]     wdata_i,
    input  logic            busy_i,
    input  logic [EV_W-1:0] ev_i,
    input  logic            rxwe_i,
    input  logic [15:0]     rx_i,
    output logic [15:0]     rdata_o,
    output logic            irq_o,
    output logic            start_o,
    output cmd_t            cmd_o,
    output logic [15:0]     tx_o
);
    typedef struct packed {
        logic [EV_W-1:0] st;
        logic [EV_W-1:0] en;
        logic [15:0]     txmb;
        logic [15:0]     rxmb;
    } rf_t;

    rf_t q, n;
    logic clr_tx;

    always_comb begin
        n = q;
        if (we_i) begin
            case (addr_i)
                OFS_STAT: n.st   = q.st & ~wdata_i[EV_HI:EV_LO];
                OFS_IEN:  n.en   = wdata_i[EV_HI:EV_LO];
                OFS_TXMB: n.txmb = wdata_i;
                default: ;
            endcase
        end
        n.st = n.st | ev_i;
        if (rxwe_i) n.rxmb = rx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (addr_i)
            OFS_STAT: rdata_o = {q.st, 13'd0};
            OFS_IEN:  rdata_o = {q.en, 13'd0};
            OFS_TXMB: rdata_o = q.txmb;
            OFS_RXMB: rdata_o = q.rxmb;
            default:  rdata_o = '0;
        endcase
    end

    assign start_o = we_i && (addr_i == OFS_CMD) && (wdata_i[15:14] == MODE_OK) && !busy_i;
    assign cmd_o   = '{addr: wdata_i[7:1], wr: wdata_i[10], two: wdata_i[11],
                       probe: wdata_i[12], hold: wdata_i[13]};
    assign tx_o    = q.txmb;
    assign irq_o   = |(q.st & q.en);

    assign clr_tx = we_i && (addr_i == OFS_STAT) && wdata_i[EV_LO+1];

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && !ev_i[1]) |=> !q.st[1]);
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st[1] && !clr_tx) |=> q.st[1]);

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int CLK_DIV = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    input  logic        scl_i,
    output logic        scl_oe,
    input  logic        sda_i,
    output logic        sda_oe
);
    logic            tick, start, busy, rxwe;
    cmd_t            cmd;
    logic [15:0]     txd, rxd;
    logic [EV_W-1:0] ev;

    i2cm_tick #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    i2cm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .busy_i  (busy),
        .ev_i    (ev),
        .rxwe_i  (rxwe),
        .rx_i    (rxd),
        .rdata_o (reg_rdata),
        .irq_o   (irq),
        .start_o (start),
        .cmd_o   (cmd),
        .tx_o    (txd)
    );

    i2cm_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start),
        .cmd_i    (cmd),
        .tx_i     (txd),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_oe_o (scl_oe),
        .sda_oe_o (sda_oe),
        .busy_o   (busy),
        .ev_o     (ev),
        .rxwe_o   (rxwe),
        .rx_o     (rxd)
    );

endmodule

// File: tb/sim_i2cm_top.sv
`timescale 1ns/100ps
module sim_i2cm_top;
    localparam int DIV = 4;
    localparam logic [6:0] SLV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq, scl_oe, sda_oe;
    logic        sl_drv = 1'b0;
    wire         scl_w = ~scl_oe;
    wire         sda_w = ~sda_oe & ~sl_drv;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    i2cm_top #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_w), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe)
    );

    // ---------------- behavioural target ----------------
    int         sstate = 0, bc = 0, rk = 0, wn = 0, nack_at = 7;
    int         starts = 0, stops = 0;
    logic       is_addr = 0, rw = 0, ps = 1, pd = 1;
    logic [7:0] sh = 0, txb = 0;
    logic [7:0] wlog [4];
    logic [1:0] mlog = 0;

    function automatic logic [7:0] rdpat(int k);
        return 8'hC0 ^ 8'(k * 19);
    endfunction

    always @(posedge clk) begin
        if (ps && scl_w && pd && !sda_w) begin
            starts++; sstate = 1; is_addr = 1; bc = 0; rk = 0; sl_drv = 0;
        end else if (ps && scl_w && !pd && sda_w) begin
            stops++; sstate = 0; sl_drv = 0;
        end else if (!ps && scl_w) begin
            if (sstate == 1) begin sh = {sh[6:0], sda_w}; bc++; end
            else if (sstate == 4) begin
                mlog = {mlog[0], sda_w};
                if (sda_w) sstate = 0;
            end
        end else if (ps && !scl_w) begin
            case (sstate)
                1: if (bc == 8) begin
                    if (is_addr) begin
                        rw = sh[0];
                        if (sh[7:1] == SLV) begin sl_drv = 1; sstate = 2; end
                        else begin sl_drv = 0; sstate = 0; end
                    end else begin
                        if (wn < 4) wlog[wn] = sh;
                        if (wn == nack_at) begin sl_drv = 0; sstate = 0; end
                        else begin sl_drv = 1; sstate = 2; end
                        wn++;
                    end
                end
                2: begin
                    if (is_addr && rw) begin
                        txb = rdpat(rk); rk++; sl_drv = ~txb[7]; bc = 1; sstate = 3;
                    end else begin
                        sl_drv = 0; is_addr = 0; bc = 0; sstate = 1;
                    end
                end
                3: if (bc == 8) begin sl_drv = 0; sstate = 4; end
                   else begin sl_drv = ~txb[7-bc]; bc++; end
                4: begin
                    txb = rdpat(rk); rk++; sl_drv = ~txb[7]; bc = 1; sstate = 3;
                end
                default: ;
            endcase
        end
        ps = scl_w; pd = sda_w;
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_ev(output logic [2:0] st);
        logic [15:0] v;
        st = 0;
        for (int i = 0; i < 40000; i++) begin
            rd(4'h0, v);
            if (v[15:13] != 0) begin st = v[15:13]; break; end
        end
    endtask

    task automatic finish_sim();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] wd;
        logic [2:0]  st;   // {rx, tx, err}
        logic [15:0] rxmb;
        logic [2:0]  wn;
        logic [7:0]  wb0;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{16'h8CA0, 16'h3412, 3'b010, 16'h0000, 3'd2, 8'h12}, // R6 two-byte write
        '{16'h84A0, 16'hBEEF, 3'b010, 16'h0000, 3'd1, 8'hEF}, // R6 one-byte write
        '{16'h80A0, 16'h0000, 3'b100, 16'h00C0, 3'd0, 8'h00}, // R7 one-byte read
        '{16'h88A0, 16'h0000, 3'b100, 16'hD3C0, 3'd0, 8'h00}, // R7 two-byte read
        '{16'h84A2, 16'h5555, 3'b001, 16'hD3C0, 3'd0, 8'h00}, // R10 address nack
        '{16'h90A0, 16'h0000, 3'b100, 16'hD3C0, 3'd0, 8'h00}, // R11 read probe ack
        '{16'h9066, 16'h0000, 3'b001, 16'hD3C0, 3'd0, 8'h00}, // R11 probe nack
        '{16'h94A0, 16'h0000, 3'b010, 16'hD3C0, 3'd0, 8'h00}  // R11 write probe ack
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual hung expected done");
        finish_sim();
    end

    initial begin
        logic [15:0] v;
        logic [2:0]  st;
        int s0, p0, cnt;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'h0, v); chk("R1 status", v, 0);
        rd(4'h2, v); chk("R1 enable", v, 0);
        rd(4'h4, v); chk("R1 txmb", v, 0);
        rd(4'h8, v); chk("R1 rxmb", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 scl idle", scl_w, 1);
        chk("R1 sda idle", sda_w, 1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wn = 0; s0 = starts; p0 = stops;
            wr(4'h4, TBL[i].wd);
            wr(4'h6, TBL[i].cmd);
            wait_ev(st);
            repeat (2) @(negedge clk);
            chk($sformatf("R5 event vec%0d", i), st, TBL[i].st);
            rd(4'h8, v); chk($sformatf("R7 rxmb vec%0d", i), v, TBL[i].rxmb);
            chk($sformatf("R6 bytes vec%0d", i), wn, TBL[i].wn);
            if (TBL[i].wn != 0) chk($sformatf("R6 first byte vec%0d", i), wlog[0], TBL[i].wb0);
            if (TBL[i].wn == 2) chk("R6 second byte", wlog[1], 8'h34);
            chk($sformatf("R9 stop vec%0d", i), stops - p0, 1);
            chk($sformatf("R9 start vec%0d", i), starts - s0, 1);
            if (i == 3) chk("R8 ack then nack", mlog, 2'b01);
            if (i == 2) chk("R8 single nack", mlog[0], 1'b1);
            wr(4'h0, 16'hE000);
        end

        // R12 SCL high time
        wr(4'h4, 16'h00A5);
        wr(4'h6, 16'h84A0);
        @(posedge scl_w);
        cnt = 0;
        @(negedge clk);
        while (scl_w) begin cnt++; @(negedge clk); end
        chk("R12 scl high cycles", cnt, 2 * DIV);
        wait_ev(st);
        repeat (2) @(negedge clk);
        wr(4'h0, 16'hE000);

        // R9 hold then repeated start
        wn = 0; s0 = starts; p0 = stops;
        wr(4'h4, 16'h0077);
        wr(4'h6, 16'hA4A0);
        wait_ev(st);
        repeat (40) @(negedge clk);
        chk("R9 hold event", st, 3'b010);
        chk("R9 no stop", stops - p0, 0);
        chk("R9 scl held low", scl_w, 0);
        wr(4'h0, 16'hE000);
        wr(4'h6, 16'h88A0);
        wait_ev(st);
        repeat (2) @(negedge clk);
        chk("R9 chained read event", st, 3'b100);
        rd(4'h8, v); chk("R9 chained data", v, 16'hD3C0);
        chk("R9 repeated start", starts - s0, 2);
        chk("R9 single stop", stops - p0, 1);
        chk("R9 held byte", wlog[0], 8'h77);
        wr(4'h0, 16'hE000);

        // R10 nack on first data byte
        wn = 0; nack_at = 0; p0 = stops;
        wr(4'h4, 16'h2211);
        wr(4'h6, 16'h8CA0);
        wait_ev(st);
        repeat (2) @(negedge clk);
        chk("R10 data nack event", st, 3'b001);
        chk("R10 no second byte", wn, 1);
        chk("R10 stop", stops - p0, 1);
        nack_at = 7;
        wr(4'h0, 16'hE000);

        // R4 bad mode ignored
        s0 = starts;
        wr(4'h6, 16'h48A0);
        repeat (200) @(negedge clk);
        rd(4'h0, v); chk("R4 bad mode status", v, 0);
        chk("R4 bad mode no start", starts - s0, 0);
        chk("R4 bad mode scl", scl_w, 1);

        // R4 command while busy ignored
        wn = 0; s0 = starts;
        wr(4'h4, 16'h0055);
        wr(4'h6, 16'h84A0);
        wr(4'h6, 16'h88A0);
        wait_ev(st);
        repeat (200) @(negedge clk);
        rd(4'h0, v); chk("R4 busy status", v, 16'h4000);
        chk("R4 busy one start", starts - s0, 1);
        chk("R4 busy byte", wlog[0], 8'h55);

        // R3 / R2 interrupt and W1C
        wr(4'h2, 16'h2000);
        @(negedge clk); chk("R3 masked irq", irq, 0);
        wr(4'h2, 16'hFFFF);
        rd(4'h2, v); chk("R1 enable bits", v, 16'hE000);
        chk("R3 irq set", irq, 1);
        wr(4'h0, 16'h2000);
        rd(4'h0, v); chk("R2 other bit kept", v, 16'h4000);
        wr(4'h0, 16'h4000);
        rd(4'h0, v); chk("R2 cleared", v, 0);
        chk("R3 irq clear", irq, 0);
        rd(4'h6, v); chk("R1 cmd reads zero", v, 0);

        finish_sim();
    end
endmodule